// File: doc/BRIEF.md
# Accessory Port Mode Select Controller

This block turns a 3-bit mode code into one-hot enables for the analog switches that share a single connector between two USB/UART host ports and three audio arrangements. It resynchronises the mode code and three status flags from a charger-detection sequencer: bus supply valid, data-line contact seen, and detection finished. It then decides which switch path may close.

Every change of path opens all paths for a programmable number of cycles before the new path closes. While the bus supply is present and detection has not finished, a move out of the all-open state to a USB port is held back. An audio selection arms an override flag. With that flag set, a later USB request closes even while detection is still pending. The flag is cleared by the all-open code and by reset.

The block also drives the left and right audio discharge terminations for whichever audio lines are not routed.

Top module: `acc_port_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released with mode code 000, `path_en` is all zeros and both `term_l_en` and `term_r_en` are 1. Reset also clears the override flag.
- R2: When the closure is permitted, a granted code sets exactly one bit of `path_en`: 001 sets bit 0 (host port 1), 010 sets bit 1 (host port 2), 011 sets bit 2 (stereo, no mic), 100 sets bit 3 (mono left with mic on D+), and 101 sets bit 4 (stereo with mic on VBUS). At most one bit is ever set.
- R3: Codes 000, 110 (reserved) and 111 (detection-reset command) leave every bit of `path_en` at 0.
- R4: `sel` and the three status inputs pass through SYNC_STAGES flops. From the all-open state, a permitted request raises its enable on the (SYNC_STAGES+1)-th rising clock edge after `sel` changes.
- R5: Hold-off is active when `vbus_ok` is 1 and `contact_ok` and `det_done` are not both 1. While hold-off is active and the override is clear, requests for 001 or 010 leave `path_en` at zero.
- R6: Codes 011, 100 and 101 close their path even during hold-off, and they set the override flag. A later 001 or 010 then closes its USB path despite hold-off.
- R7: Sampling code 000 clears the override flag. After it, a USB request under hold-off stays open again.
- R8: With `vbus_ok`, `contact_ok` and `det_done` all 1, a USB request from the all-open state closes without any override.
- R9: When the requested path changes while a path is closed, `path_en` is zero for exactly GAP_CYCLES cycles before the new enable rises. A non-zero enable never changes directly into a different non-zero value.
- R10: `term_l_en` is 0 exactly when bit 2, 3 or 4 of `path_en` is set. `term_r_en` is 0 exactly when bit 2 or 4 is set, so the mono mode leaves the right line terminated.
- R11: Hold-off is only judged when a path closes. A USB path that is already closed stays closed when hold-off appears afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 3 | Mode code (asynchronous to clk) |
| vbus_ok | input | 1 | Bus supply valid from the detection sequencer |
| contact_ok | input | 1 | Data-line contact detected |
| det_done | input | 1 | Charger detection finished |
| path_en | output | 5 | One-hot switch path enables (bit map in R2) |
| term_l_en | output | 1 | Left audio line discharge termination enable |
| term_r_en | output | 1 | Right audio line discharge termination enable |

## Verification
The bench builds the block with SYNC_STAGES = 2 and GAP_CYCLES = 3. A three-cycle break window lets the bench count the open gap cycle by cycle and tell it apart from a single-cycle or missing break. The two-flop input path fixes an exact edge on which the first enable must rise. With these values, every hold-off, override and clearing sequence completes within a few dozen cycles, so each ordering of audio, USB and all-open codes can be walked directly.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int SEL_W     = 3;
  localparam int NUM_PATHS = 5;

  // bit positions of the path enable vector
  localparam int P_HOST1     = 0;
  localparam int P_HOST2     = 1;
  localparam int P_STEREO    = 2;
  localparam int P_MONO_MIC  = 3;
  localparam int P_STEREO_MV = 4;

  typedef enum logic [SEL_W-1:0] {
    MODE_OPEN      = 3'b000,
    MODE_HOST1     = 3'b001,
    MODE_HOST2     = 3'b010,
    MODE_STEREO    = 3'b011,
    MODE_MONO_MIC  = 3'b100,
    MODE_STEREO_MV = 3'b101,
    MODE_RESERVED  = 3'b110,
    MODE_DET_RESET = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLOSED = 2'd1,
    ST_BREAK  = 2'd2
  } path_state_e;

endpackage

// File: rtl/acc_sync.sv
module acc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d;
      end
      assign q = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/acc_mode_decode.sv
module acc_mode_decode
  import acc_pkg::*;
(
  input  logic [SEL_W-1:0]     mode,
  output logic [NUM_PATHS-1:0] req,
  output logic                 is_open,
  output logic                 is_usb,
  output logic                 is_audio
);

  always_comb begin
    req      = '0;
    is_open  = 1'b0;
    is_usb   = 1'b0;
    is_audio = 1'b0;
    unique case (mode_e'(mode))
      MODE_OPEN:      is_open = 1'b1;
      MODE_HOST1:     begin req[P_HOST1]     = 1'b1; is_usb   = 1'b1; end
      MODE_HOST2:     begin req[P_HOST2]     = 1'b1; is_usb   = 1'b1; end
      MODE_STEREO:    begin req[P_STEREO]    = 1'b1; is_audio = 1'b1; end
      MODE_MONO_MIC:  begin req[P_MONO_MIC]  = 1'b1; is_audio = 1'b1; end
      MODE_STEREO_MV: begin req[P_STEREO_MV] = 1'b1; is_audio = 1'b1; end
      MODE_RESERVED:  req = '0;
      MODE_DET_RESET: req = '0;
      default:        req = '0;
    endcase
  end

endmodule

// File: rtl/acc_close_gate.sv
module acc_close_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic is_open,
  input  logic is_audio,
  input  logic vbus_ok,
  input  logic contact_ok,
  input  logic det_done,
  output logic holdoff,
  output logic ovr_q,
  output logic grant
);

  logic ovr_d;
  logic ovr_en;

  assign holdoff = vbus_ok & ~(contact_ok & det_done);

  // next-state: the all-open code clears, an audio code arms
  always_comb begin
    ovr_en = is_open | is_audio;
    ovr_d  = ovr_q;
    if (is_open)       ovr_d = 1'b0;
    else if (is_audio) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= 1'b0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  assign grant = ~holdoff | is_audio | ovr_q;

endmodule

// File: rtl/acc_path_fsm.sv
module acc_path_fsm
  import acc_pkg::*;
#(
  parameter int NPATH      = NUM_PATHS,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPATH-1:0] req,
  input  logic             grant,
  output logic [NPATH-1:0] path_en
);

  localparam int GAP   = (GAP_CYCLES < 1) ? 1 : GAP_CYCLES;
  localparam int CNT_W = (GAP < 2) ? 1 : $clog2(GAP);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP - 1);

  path_state_e      state_q, state_d;
  logic [NPATH-1:0] cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             want_close;

  assign want_close = (|req) & grant;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (want_close) begin
          state_d = ST_CLOSED;
          cur_d   = req;
        end
      end
      ST_CLOSED: begin
        if (req != cur_q) begin
          state_d = ST_BREAK;
          cur_d   = '0;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_BREAK: begin
        if (cnt_q == CNT_LAST) begin
          if (want_close) begin
            state_d = ST_CLOSED;
            cur_d   = req;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cur_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign path_en = (state_q == ST_CLOSED) ? cur_q : '0;

endmodule

// File: rtl/acc_port_mode_ctrl.sv
module acc_port_mode_ctrl
  import acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 vbus_ok,
  input  logic                 contact_ok,
  input  logic                 det_done,
  output logic [NUM_PATHS-1:0] path_en,
  output logic                 term_l_en,
  output logic                 term_r_en
);

  localparam int IN_W = SEL_W + 3;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  logic [IN_W-1:0]      in_raw, in_s;
  logic [SEL_W-1:0]     sel_s;
  logic                 vbus_s, contact_s, done_s;
  logic [NUM_PATHS-1:0] req;
  logic                 is_open, is_usb, is_audio;
  logic                 holdoff, ovr_q, grant;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign in_raw = {sel, vbus_ok, contact_ok, det_done};

  acc_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (in_raw),
    .q     (in_s)
  );

  assign sel_s     = in_s[IN_W-1:3];
  assign vbus_s    = in_s[2];
  assign contact_s = in_s[1];
  assign done_s    = in_s[0];

  acc_mode_decode u_dec (
    .mode     (sel_s),
    .req      (req),
    .is_open  (is_open),
    .is_usb   (is_usb),
    .is_audio (is_audio)
  );

  acc_close_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .is_open    (is_open),
    .is_audio   (is_audio),
    .vbus_ok    (vbus_s),
    .contact_ok (contact_s),
    .det_done   (done_s),
    .holdoff    (holdoff),
    .ovr_q      (ovr_q),
    .grant      (grant)
  );

  acc_path_fsm #(.NPATH(NUM_PATHS), .GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .grant   (grant),
    .path_en (path_en)
  );

  // discharge any audio line that is not routed
  assign term_l_en = ~(path_en[P_STEREO] | path_en[P_MONO_MIC] | path_en[P_STEREO_MV]);
  assign term_r_en = ~(path_en[P_STEREO] | path_en[P_STEREO_MV]);

  logic unused_usb;
  assign unused_usb = is_usb;

endmodule

// File: rtl/acc_port_mode_ctrl_chk.sv
module acc_port_mode_ctrl_chk
  import acc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PATHS-1:0] path_en,
  input logic                 term_l_en,
  input logic                 term_r_en,
  input logic [SEL_W-1:0]     sel_s,
  input logic                 holdoff,
  input logic                 ovr_q
);

  // R2: never more than one path closed
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(path_en));

  // R9: a closed path never turns straight into another closed path
  a_r9_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(path_en) != '0) && (path_en != '0)) |-> (path_en == $past(path_en)));

  // R10: with nothing routed both lines are terminated
  a_r10_term_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en == '0) |-> (term_l_en && term_r_en));

  // R10: mono mode keeps the right line terminated
  a_r10_mono_right: assert property (@(posedge clk) disable iff (!rst_n)
    path_en[P_MONO_MIC] |-> (term_r_en && !term_l_en));

  // R5: a USB path only closes when hold-off is clear or overridden
  a_r5_usb_permit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_en[P_HOST1] | path_en[P_HOST2]) |-> $past(!holdoff || ovr_q));

  // R7: the all-open code clears the override
  a_r7_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s == MODE_OPEN) |=> !ovr_q);

  // R3: codes that close nothing keep everything open once open
  a_r3_no_close: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_s == MODE_RESERVED || sel_s == MODE_DET_RESET || sel_s == MODE_OPEN)
     && path_en == '0) |=> (path_en == '0));

endmodule

bind acc_port_mode_ctrl acc_port_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .path_en   (path_en),
  .term_l_en (term_l_en),
  .term_r_en (term_r_en),
  .sel_s     (sel_s),
  .holdoff   (holdoff),
  .ovr_q     (ovr_q)
);

// File: tb/acc_port_mode_ctrl_tb.sv
module acc_port_mode_ctrl_tb;

  localparam int SYNC = 2;
  localparam int GAP  = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       vbus_ok, contact_ok, det_done;
  logic [4:0] path_en;
  logic       term_l_en, term_r_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_port_mode_ctrl #(.SYNC_STAGES(SYNC), .GAP_CYCLES(GAP)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .vbus_ok    (vbus_ok),
    .contact_ok (contact_ok),
    .det_done   (det_done),
    .path_en    (path_en),
    .term_l_en  (term_l_en),
    .term_r_en  (term_r_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic go(input logic [2:0] code);
    @(negedge clk);
    sel = code;
    settle();
  endtask

  function automatic logic [4:0] exp_en(input logic [2:0] code);
    case (code)
      3'b001:  return 5'b00001;
      3'b010:  return 5'b00010;
      3'b011:  return 5'b00100;
      3'b100:  return 5'b01000;
      3'b101:  return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    sel = 3'b000; vbus_ok = 0; contact_ok = 0; det_done = 0;
    repeat (3) @(negedge clk);
    check(path_en == 0, "R1", "path_en in reset", path_en, 0);
    check(term_l_en && term_r_en, "R1", "terminations in reset", {term_l_en, term_r_en}, 3);
    rst_n = 1'b1;
    settle();
    check(path_en == 0, "R1", "path_en after reset", path_en, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    sel = 3'b001;
    repeat (SYNC) @(negedge clk);
    check(path_en == 0, "R4", "enable before last edge", path_en, 0);
    @(negedge clk);
    check(path_en == 5'b00001, "R4", "enable on edge SYNC+1", path_en, 1);
    go(3'b000);
  endtask

  task automatic t_decode();
    logic [2:0] codes [5] = '{3'b011, 3'b100, 3'b101, 3'b010, 3'b001};
    logic [4:0] e;
    for (int i = 0; i < 5; i++) begin
      go(codes[i]);
      e = exp_en(codes[i]);
      check(path_en == e, "R2", "decoded path", path_en, e);
      check(term_l_en == !(e[2] | e[3] | e[4]), "R10", "left term", term_l_en, !(e[2]|e[3]|e[4]));
      check(term_r_en == !(e[2] | e[4]), "R10", "right term", term_r_en, !(e[2]|e[4]));
    end
  endtask

  task automatic t_no_close_codes();
    logic [2:0] codes [3] = '{3'b110, 3'b111, 3'b000};
    for (int i = 0; i < 3; i++) begin
      go(codes[i]);
      check(path_en == 0, "R3", "code closes nothing", path_en, 0);
      check(term_l_en && term_r_en, "R10", "terms with none routed", {term_l_en, term_r_en}, 3);
    end
  endtask

  task automatic t_break();
    int zeros;
    go(3'b001);
    @(negedge clk);
    sel = 3'b010;
    zeros = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (path_en == 5'b00010) break;
      if (path_en == 0) zeros++;
      else if (path_en != 5'b00001)
        check(0, "R9", "unexpected enable during switch", path_en, 0);
    end
    check(zeros == GAP, "R9", "open gap cycles", zeros, GAP);
    check(path_en == 5'b00010, "R9", "new path after gap", path_en, 2);
    go(3'b000);
  endtask

  task automatic t_holdoff_override();
    @(negedge clk);
    vbus_ok = 1; contact_ok = 0; det_done = 0;
    go(3'b000);
    go(3'b001);
    check(path_en == 0, "R5", "host1 held off", path_en, 0);
    go(3'b010);
    check(path_en == 0, "R5", "host2 held off", path_en, 0);
    go(3'b011);
    check(path_en == 5'b00100, "R6", "audio closes under hold-off", path_en, 4);
    go(3'b001);
    check(path_en == 5'b00001, "R6", "usb after audio override", path_en, 1);
    go(3'b000);
    go(3'b010);
    check(path_en == 0, "R7", "override cleared by open", path_en, 0);
  endtask

  task automatic t_det_complete();
    go(3'b000);
    @(negedge clk);
    contact_ok = 1; det_done = 1;
    go(3'b001);
    check(path_en == 5'b00001, "R8", "usb after detection done", path_en, 1);
    @(negedge clk);
    contact_ok = 0;
    settle();
    check(path_en == 5'b00001, "R11", "closed path survives new hold-off", path_en, 1);
  endtask

  task automatic t_reset_clears_override();
    go(3'b100);
    check(path_en == 5'b01000, "R6", "mono arms override", path_en, 8);
    @(negedge clk);
    rst_n = 1'b0;
    sel = 3'b001;
    repeat (2) @(negedge clk);
    check(path_en == 0, "R1", "reset opens path", path_en, 0);
    rst_n = 1'b1;
    settle();
    check(path_en == 0, "R1", "override cleared by reset", path_en, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_decode();
    t_no_close_codes();
    t_break();
    t_holdoff_override();
    t_det_complete();
    t_reset_clears_override();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule